// File: doc/BRIEF.md
# Command-Gated Serial Register Interface

This block is the device-side serial port of a converter-style peripheral. A host reaches a small register file through it with a serial clock, a data input, a data output and an optional active-low select. Each access opens with an 8-bit command byte. The command byte sets the direction and the target of exactly one following access. After that access the port waits for a new command byte. A 24-bit result register holds conversion words. New words reach it on a parallel strobe from the converter core, which is outside this block. An active-low ready output shows when an unread word is waiting.

The serial clock is oversampled in the system clock domain. A polarity input sets which serial clock level counts as idle. The select may be tied low, which gives three-wire use. In that case the host reads the ready state from the top bit of the command register. If the host loses framing, it can hold the data input high for a long run of clocks. This puts the port back to waiting for a command byte and leaves the stored registers as they were.

Top module: `ser_regif`

## Requirements
- R1: After reset, `rdy_n_o` is 1, `dout_o` is 0, and the first 8 bits the host clocks in are taken as a command byte.
- R2: Command byte layout: bit 3 set means read and clear means write, and bits 6:4 select the target (0 command register, 1 to 3 general registers, 5 result register). After the one access that the command selects, the next byte is again a command. A write command that selects address 0 has no data phase.
- R3: A write to a general register stores the 8 bits that follow the command, MSB first, and a later read returns them.
- R4: Reads shift out MSB first. `dout_o` changes only on a falling edge of the effective serial clock. The result register is 24 bits long and every other register is 8 bits long.
- R5: A conversion strobe drives `rdy_n_o` high at least one system cycle before the result register takes the new word. `rdy_n_o` goes low in the cycle the word is loaded.
- R6: `rdy_n_o` returns high when a read of the result register completes.
- R7: The host can read the result register again after `rdy_n_o` has gone high, and it gets the same word.
- R8: A strobe that arrives while a result read is in progress is held. The read returns the old word. The new word is loaded after the read ends, and `rdy_n_o` then goes low.
- R9: A read of the command register returns `{rdy_n_o, command bits 6:0}` for the command that requested it.
- R10: With `pol_i` low, the port works the same way with the serial clock inverted.
- R11: Holding `din_i` at 1 for 32 or more consecutive rising edges returns the port to waiting for a command byte. General register contents are not changed.
- R12: Raising `cs_n_i` aborts any partial transaction. Serial edges are ignored while `cs_n_i` is high.
- R13: Writes to the result register or to unused addresses have no effect. Reads of unused addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, used to oversample the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock from the host |
| cs_n_i | input | 1 | Active-low select; tie low for three-wire use |
| din_i | input | 1 | Serial data from the host |
| pol_i | input | 1 | Clock polarity: 1 native, 0 inverted |
| dout_o | output | 1 | Serial data to the host |
| rdy_n_o | output | 1 | Low while an unread conversion word is waiting |
| conv_valid_i | input | 1 | One-cycle strobe carrying a new conversion word |
| conv_data_i | input | 24 | Conversion word presented with the strobe |

## Verification
The assertions take for granted that each serial clock level lasts several system cycles, so that every edge is seen exactly once. They also assume that `pol_i` changes only while `cs_n_i` is high, and that conversion strobes are far enough apart for a held word to be loaded before the next one arrives. The bench drives every serial level for four system cycles. It changes polarity only inside a deselected window, with the idle level set to match, and it leaves hundreds of cycles between strobes. Random register traffic and conversion words are mixed with directed aborts, ones-run recovery and reads that overlap a strobe.

// File: rtl/ser_regif_pkg.sv
package ser_regif_pkg;

    localparam int BYTE_W = 8;
    localparam int SEL_W  = 3;
    localparam int SEL_HI = 6;
    localparam int SEL_LO = 4;
    localparam int RD_BIT = 3;

    localparam logic [SEL_W-1:0] SEL_COMM = 3'd0;
    localparam logic [SEL_W-1:0] SEL_DATA = 3'd5;

    typedef enum logic [1:0] {
        ST_CMD,
        ST_WR,
        ST_RD
    } seq_st_e;

    // length in bits of a read phase for a given target
    function automatic int unsigned xfer_len(input logic [SEL_W-1:0] sel,
                                             input int unsigned data_w);
        return (sel == SEL_DATA) ? data_w : BYTE_W;
    endfunction

endpackage

// File: rtl/ser_edge.sv
module ser_edge (
    input  logic clk,
    input  logic rst,
    input  logic sclk,
    input  logic pol,
    input  logic cs_n,
    output logic rise,
    output logic fall
);
    logic eff;
    logic eff_q;

    // effective clock idles high for either polarity
    assign eff = ~(sclk ^ pol);

    always_ff @(posedge clk) begin
        if (rst) eff_q <= 1'b1;
        else     eff_q <= eff;
    end

    assign rise = !cs_n &&  eff && !eff_q;
    assign fall = !cs_n && !eff &&  eff_q;
endmodule

// File: rtl/ser_regfile.sv
module ser_regfile
    import ser_regif_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int NUM_GP = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [SEL_W-1:0]  rd_addr,
    output logic [DATA_W-1:0] rd_word,
    input  logic              rd_done,
    input  logic              reading,
    input  logic              conv_valid,
    input  logic [DATA_W-1:0] conv_data,
    output logic              rdy_n
);
    localparam int PAD_W = DATA_W - BYTE_W;

    logic [NUM_GP-1:0][BYTE_W-1:0] gp_q;
    logic [DATA_W-1:0]             data_q;
    logic [DATA_W-1:0]             pend_d;
    logic                          pend_q;
    logic                          rdy_n_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gp_q <= '0;
        end else if (wr_en) begin
            for (int g = 0; g < NUM_GP; g++) begin
                if (wr_addr == SEL_W'(g + 1)) gp_q[g] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_word = '0;
        if (rd_addr == SEL_DATA) rd_word = data_q;
        for (int g = 0; g < NUM_GP; g++) begin
            if (rd_addr == SEL_W'(g + 1)) rd_word = {gp_q[g], {PAD_W{1'b0}}};
        end
    end

    // result register, held word and ready flag
    always_ff @(posedge clk) begin
        if (rst) begin
            data_q  <= '0;
            pend_d  <= '0;
            pend_q  <= 1'b0;
            rdy_n_q <= 1'b1;
        end else begin
            if (rd_done) rdy_n_q <= 1'b1;
            if (pend_q && !reading) begin
                data_q  <= pend_d;
                pend_q  <= 1'b0;
                rdy_n_q <= 1'b0;
            end
            if (conv_valid) begin
                pend_q  <= 1'b1;
                pend_d  <= conv_data;
                rdy_n_q <= 1'b1;
            end
        end
    end

    assign rdy_n = rdy_n_q;
endmodule

// File: rtl/ser_seq.sv
module ser_seq
    import ser_regif_pkg::*;
#(
    parameter int DATA_W     = 24,
    parameter int ONES_LIMIT = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rise,
    input  logic              fall,
    input  logic              cs_n,
    input  logic              din,
    input  logic              rdy_n,
    input  logic [DATA_W-1:0] rd_word,
    output logic [SEL_W-1:0]  rd_addr,
    output logic              wr_en,
    output logic [SEL_W-1:0]  wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              data_rd_done,
    output logic              data_reading,
    output logic              dout
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam int OC_W  = $clog2(ONES_LIMIT + 1);
    localparam int PAD_W = DATA_W - BYTE_W;

    seq_st_e           state_q;
    logic [CNT_W-1:0]  bit_cnt;
    logic [CNT_W-1:0]  last_q;
    logic [BYTE_W-1:0] rx_sr;
    logic [DATA_W-1:0] tx_sr;
    logic [SEL_W-1:0]  tgt_q;
    logic              dout_q;
    logic [OC_W-1:0]   ones_q;
    logic              ones_hit;

    logic [BYTE_W-1:0] in_byte;
    logic [SEL_W-1:0]  in_sel;
    logic              in_rd;
    logic              byte_end;
    logic              live;

    assign in_byte  = {rx_sr[BYTE_W-2:0], din};
    assign in_sel   = in_byte[SEL_HI:SEL_LO];
    assign in_rd    = in_byte[RD_BIT];
    assign byte_end = rise && (bit_cnt == CNT_W'(BYTE_W - 1));
    assign ones_hit = rise && din && (ones_q >= OC_W'(ONES_LIMIT - 1));
    assign live     = !cs_n && !ones_hit;

    assign rd_addr      = in_sel;
    assign wr_en        = live && byte_end && (state_q == ST_WR);
    assign wr_addr      = tgt_q;
    assign wr_data      = in_byte;
    assign data_reading = (state_q == ST_RD) && (tgt_q == SEL_DATA);
    assign data_rd_done = live && rise && data_reading && (bit_cnt == last_q);
    assign dout         = dout_q;

    // run-of-ones detector, saturating
    always_ff @(posedge clk) begin
        if (rst || cs_n) begin
            ones_q <= '0;
        end else if (rise) begin
            if (!din)                            ones_q <= '0;
            else if (ones_q < OC_W'(ONES_LIMIT)) ones_q <= ones_q + OC_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_CMD;
            bit_cnt <= '0;
            last_q  <= '0;
            rx_sr   <= '0;
            tx_sr   <= '0;
            tgt_q   <= SEL_COMM;
            dout_q  <= 1'b0;
        end else if (!live) begin
            state_q <= ST_CMD;
            bit_cnt <= '0;
        end else begin
            if (rise) begin
                unique case (state_q)
                    ST_CMD: begin
                        rx_sr <= in_byte;
                        if (byte_end) begin
                            bit_cnt <= '0;
                            tgt_q   <= in_sel;
                            last_q  <= CNT_W'(xfer_len(in_sel, DATA_W) - 1);
                            if (in_rd) begin
                                state_q <= ST_RD;
                                tx_sr   <= (in_sel == SEL_COMM) ?
                                           {rdy_n, in_byte[BYTE_W-2:0], {PAD_W{1'b0}}} :
                                           rd_word;
                            end else if (in_sel != SEL_COMM) begin
                                state_q <= ST_WR;
                            end
                        end else begin
                            bit_cnt <= bit_cnt + CNT_W'(1);
                        end
                    end
                    ST_WR: begin
                        rx_sr <= in_byte;
                        if (byte_end) begin
                            state_q <= ST_CMD;
                            bit_cnt <= '0;
                        end else begin
                            bit_cnt <= bit_cnt + CNT_W'(1);
                        end
                    end
                    ST_RD: begin
                        if (bit_cnt == last_q) begin
                            state_q <= ST_CMD;
                            bit_cnt <= '0;
                        end else begin
                            bit_cnt <= bit_cnt + CNT_W'(1);
                        end
                    end
                    default: state_q <= ST_CMD;
                endcase
            end
            if (fall && state_q == ST_RD) begin
                dout_q <= tx_sr[DATA_W-1];
                tx_sr  <= {tx_sr[DATA_W-2:0], 1'b0};
            end
        end
    end
endmodule

// File: rtl/ser_regif.sv
module ser_regif
    import ser_regif_pkg::*;
#(
    parameter int DATA_W     = 24,
    parameter int NUM_GP     = 3,
    parameter int ONES_LIMIT = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_i,
    input  logic              cs_n_i,
    input  logic              din_i,
    input  logic              pol_i,
    output logic              dout_o,
    output logic              rdy_n_o,
    input  logic              conv_valid_i,
    input  logic [DATA_W-1:0] conv_data_i
);
    logic              sclk_rise;
    logic              sclk_fall;
    logic [SEL_W-1:0]  rd_addr;
    logic [DATA_W-1:0] rd_word;
    logic              wr_en;
    logic [SEL_W-1:0]  wr_addr;
    logic [BYTE_W-1:0] wr_data;
    logic              data_rd_done;
    logic              data_reading;

    ser_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .sclk (sclk_i),
        .pol  (pol_i),
        .cs_n (cs_n_i),
        .rise (sclk_rise),
        .fall (sclk_fall)
    );

    ser_seq #(.DATA_W(DATA_W), .ONES_LIMIT(ONES_LIMIT)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .rise         (sclk_rise),
        .fall         (sclk_fall),
        .cs_n         (cs_n_i),
        .din          (din_i),
        .rdy_n        (rdy_n_o),
        .rd_word      (rd_word),
        .rd_addr      (rd_addr),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .data_rd_done (data_rd_done),
        .data_reading (data_reading),
        .dout         (dout_o)
    );

    ser_regfile #(.DATA_W(DATA_W), .NUM_GP(NUM_GP)) u_rf (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_word    (rd_word),
        .rd_done    (data_rd_done),
        .reading    (data_reading),
        .conv_valid (conv_valid_i),
        .conv_data  (conv_data_i),
        .rdy_n      (rdy_n_o)
    );
endmodule

// File: rtl/ser_regif_chk.sv
module ser_regif_chk
    import ser_regif_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input logic              clk,
    input logic              rst,
    input logic              cs_n_i,
    input logic              dout_o,
    input logic              rdy_n_o,
    input logic              sclk_fall,
    input logic              data_rd_done,
    input logic              data_reading,
    input logic              ones_hit,
    input seq_st_e           state,
    input logic [DATA_W-1:0] data_q
);
    // R4
    dout_edge_chk: assert property (@(posedge clk) disable iff (rst)
        !sclk_fall |=> $stable(dout_o));

    // R5
    rdy_before_load_chk: assert property (@(posedge clk) disable iff (rst)
        (data_q != $past(data_q)) |-> $past(rdy_n_o));

    // R6
    rdy_after_read_chk: assert property (@(posedge clk) disable iff (rst)
        data_rd_done |=> rdy_n_o);

    // R8
    hold_during_read_chk: assert property (@(posedge clk) disable iff (rst)
        data_reading |=> $stable(data_q));

    // R11
    ones_recover_chk: assert property (@(posedge clk) disable iff (rst)
        ones_hit |=> (state == ST_CMD));

    // R12
    cs_abort_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n_i |=> (state == ST_CMD));
endmodule

bind ser_regif ser_regif_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cs_n_i       (cs_n_i),
    .dout_o       (dout_o),
    .rdy_n_o      (rdy_n_o),
    .sclk_fall    (sclk_fall),
    .data_rd_done (data_rd_done),
    .data_reading (data_reading),
    .ones_hit     (u_seq.ones_hit),
    .state        (u_seq.state_q),
    .data_q       (u_rf.data_q)
);

// File: tb/ser_regif_tb_top.sv
module ser_regif_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sclk = 1'b1;
    logic        cs_n = 1'b1;
    logic        din = 1'b0;
    logic        pol = 1'b1;
    logic        conv_valid = 1'b0;
    logic [23:0] conv_data = '0;
    logic        dout;
    logic        rdy_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [7:0]  gp_m [1:3];
    logic [23:0] data_m;
    logic        rdy_m;

    always #(CLK_PERIOD/2) clk = ~clk;

    ser_regif dut_i (
        .clk          (clk),
        .rst          (rst),
        .sclk_i       (sclk),
        .cs_n_i       (cs_n),
        .din_i        (din),
        .pol_i        (pol),
        .dout_o       (dout),
        .rdy_n_o      (rdy_n),
        .conv_valid_i (conv_valid),
        .conv_data_i  (conv_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_xfer(input logic b, output logic q);
        sclk = ~pol;
        din  = b;
        wait_clks(HALF);
        sclk = pol;
        wait_clks(HALF);
        q = dout;
    endtask

    task automatic xfer(input logic [23:0] tx, input int n, output logic [23:0] rx);
        logic q;
        rx = '0;
        for (int i = n - 1; i >= 0; i--) begin
            bit_xfer(tx[i], q);
            rx = {rx[22:0], q};
        end
    endtask

    task automatic send_cmd(input logic [2:0] sel, input logic rd);
        logic [23:0] junk;
        xfer({16'h0, 1'b0, sel, rd, 3'b000}, 8, junk);
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] v);
        logic [23:0] junk;
        send_cmd(a, 1'b0);
        xfer({16'h0, v}, 8, junk);
        if (a >= 3'd1 && a <= 3'd3) gp_m[a] = v;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [23:0] v);
        send_cmd(a, 1'b1);
        xfer(24'h0, (a == 3'd5) ? 24 : 8, v);
        if (a == 3'd5) rdy_m = 1'b1;
    endtask

    function automatic logic [23:0] exp_rd(input logic [2:0] a);
        if (a == 3'd5) return data_m;
        if (a >= 3'd1 && a <= 3'd3) return {16'h0, gp_m[a]};
        return 24'h0;
    endfunction

    task automatic conv(input logic [23:0] d, input bit loads);
        @(negedge clk);
        conv_valid = 1'b1;
        conv_data  = d;
        @(negedge clk);
        conv_valid = 1'b0;
        chk("R5 ready high before load", {31'h0, rdy_n}, 32'h1);
        if (loads) begin
            @(negedge clk);
            chk("R5 ready low after load", {31'h0, rdy_n}, 32'h0);
            data_m = d;
            rdy_m  = 1'b0;
        end
    endtask

    task automatic set_pol(input logic p);
        cs_n = 1'b1;
        wait_clks(2);
        pol  = p;
        sclk = p;
        wait_clks(2);
        cs_n = 1'b0;
        wait_clks(2);
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog actual=hung expected=complete");
            finish_run();
        end
    end

    initial begin
        logic [23:0] v;
        logic [23:0] hi;
        logic [23:0] lo;
        logic [7:0]  g1;
        void'($urandom(32'd4242));
        gp_m[1] = 8'h0; gp_m[2] = 8'h0; gp_m[3] = 8'h0;
        data_m = '0;
        rdy_m  = 1'b1;

        wait_clks(5);
        rst = 1'b0;
        wait_clks(2);
        chk("R1 ready after reset", {31'h0, rdy_n}, 32'h1);
        chk("R1 dout after reset", {31'h0, dout}, 32'h0);
        cs_n = 1'b0;
        wait_clks(2);

        // first byte is a command: read the command register
        rd_reg(3'd0, v);
        chk("R1 R9 command readback", v, {16'h0, 1'b1, 7'h08});

        // general registers
        wr_reg(3'd1, 8'hA5);
        wr_reg(3'd2, 8'h3C);
        wr_reg(3'd3, 8'h81);
        rd_reg(3'd1, v); chk("R2 R3 gp1", v, exp_rd(3'd1));
        rd_reg(3'd2, v); chk("R3 gp2", v, exp_rd(3'd2));
        rd_reg(3'd3, v); chk("R3 gp3", v, exp_rd(3'd3));

        // conversion, ready in command register, 24-bit read, reread
        conv(24'h123456, 1);
        rd_reg(3'd0, v);
        chk("R9 ready bit low", v, {16'h0, 1'b0, 7'h08});
        rd_reg(3'd5, v);
        chk("R4 result word", v, 24'h123456);
        chk("R6 ready high after read", {31'h0, rdy_n}, 32'h1);
        rd_reg(3'd5, v);
        chk("R7 reread same word", v, 24'h123456);
        chk("R7 ready stays high", {31'h0, rdy_n}, 32'h1);

        // strobe during result read
        conv(24'hABCDEF, 1);
        send_cmd(3'd5, 1'b1);
        xfer(24'h0, 10, hi);
        conv(24'h654321, 0);
        xfer(24'h0, 14, lo);
        chk("R8 read returns old word", {hi[9:0], lo[13:0]}, 24'hABCDEF);
        chk("R8 ready low after held load", {31'h0, rdy_n}, 32'h0);
        data_m = 24'h654321;
        rd_reg(3'd5, v);
        chk("R8 held word loaded", v, 24'h654321);

        // select abort and ignored edges
        xfer(24'h0, 4, v);
        cs_n = 1'b1;
        wait_clks(2);
        xfer(24'h00_0001, 16, v);
        cs_n = 1'b0;
        wait_clks(2);
        rd_reg(3'd1, v);
        chk("R12 abort leaves gp1", v, exp_rd(3'd1));

        // ones run recovery
        xfer(24'h0, 3, v);
        for (int i = 0; i < 40; i++) bit_xfer(1'b1, g1[0]);
        rd_reg(3'd2, v);
        chk("R11 port recovered", v, exp_rd(3'd2));
        rd_reg(3'd1, v);
        chk("R11 gp1 unchanged", v, exp_rd(3'd1));
        send_cmd(3'd1, 1'b1);
        for (int i = 0; i < 36; i++) bit_xfer(1'b1, g1[0]);
        rd_reg(3'd3, v);
        chk("R11 recovery from read", v, exp_rd(3'd3));

        // inverted clock polarity
        set_pol(1'b0);
        wr_reg(3'd3, 8'h5A);
        rd_reg(3'd3, v);
        chk("R10 gp3 inverted clock", v, exp_rd(3'd3));
        rd_reg(3'd5, v);
        chk("R10 result inverted clock", v, data_m);
        set_pol(1'b1);

        // ignored writes, unused reads
        wr_reg(3'd5, 8'h00);
        rd_reg(3'd5, v);
        chk("R13 result not writable", v, data_m);
        wr_reg(3'd6, 8'hFF);
        rd_reg(3'd6, v);
        chk("R13 unused addr 6", v, 24'h0);
        rd_reg(3'd4, v);
        chk("R13 unused addr 4", v, 24'h0);

        // random traffic
        for (int it = 0; it < 60; it++) begin
            int unsigned op;
            logic [2:0]  a;
            logic [7:0]  b;
            op = $urandom % 4;
            a  = 3'($urandom % 3 + 1);
            b  = 8'($urandom);
            case (op)
                0: wr_reg(a, b);
                1: begin
                    rd_reg(a, v);
                    chk("R3 random gp read", v, exp_rd(a));
                end
                2: begin
                    conv(24'($urandom), 1);
                    rd_reg(3'd0, v);
                    chk("R9 random ready bit", v, {16'h0, rdy_m, 7'h08});
                    rd_reg(3'd5, v);
                    chk("R4 random result read", v, data_m);
                    chk("R6 random ready", {31'h0, rdy_n}, 32'h1);
                end
                default: begin
                    a = (b[0]) ? 3'd7 : 3'd6;
                    rd_reg(a, v);
                    chk("R13 random unused read", v, 24'h0);
                end
            endcase
        end

        done = 1;
        finish_run();
    end
endmodule